// File: doc/BRIEF.md
# Packed unsigned saturating add/subtract unit

The unit performs SIMD arithmetic on a 32-bit word. It takes two unsigned operands and a 3-bit operation code. It treats the word either as two halfword lanes or as four byte lanes. Each lane adds or subtracts on its own and clamps its own result to the unsigned range of the lane. A result that would pass the top of the range becomes all ones. A result that would go below zero becomes zero.

Two exchange operations pair the low halfword of operand A with the high halfword of operand B, and the high halfword of A with the low halfword of B. One of the two halfword lanes adds and the other subtracts.

The unit sets no condition flags. A per-byte saturation indicator is provided for observation only. The result passes through an optional output register, which is selected by a parameter and is enabled by default. With the register in place, the result of an operation appears one clock after the operands are presented.

Top module: `psat_unit`

## Requirements
- R1: Code 000 adds halfword lanes [15:0] and [31:16] separately. A lane sum of 0x10000 or more gives 0xFFFF in that lane.
- R2: Code 001 adds byte lanes [7:0], [15:8], [23:16] and [31:24] separately. A lane sum of 0x100 or more gives 0xFF in that lane.
- R3: Code 010 subtracts B from A in each halfword lane. A negative lane difference gives 0x0000.
- R4: Code 011 subtracts B from A in each byte lane. A negative lane difference gives 0x00.
- R5: Code 100 is an exchange operation with two saturated halfword results:
  - result[15:0] = A[15:0] − B[31:16];
  - result[31:16] = A[31:16] + B[15:0].
- R6: Code 101 is an exchange operation with two saturated halfword results:
  - result[15:0] = A[15:0] + B[31:16];
  - result[31:16] = A[31:16] − B[15:0].
- R7: A lane that does not saturate returns the exact sum or difference. No carry or borrow crosses a lane boundary, including when a neighbouring lane clamps.
- R8: Codes 110 and 111 give a result of zero and a saturation output of zero.
- R9: sat_o bit k covers byte position k.
  - It is 1 exactly when the lane that holds that byte clamped.
  - A halfword lane drives both of its bits.
- R10: While rst_ni is low, res_o and sat_o are zero. With the output register enabled, the outputs follow the inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| res_o | output | 32 | Saturated packed result |
| sat_o | output | 4 | Per-byte saturation indicator, for observation only |

## Verification
The hardest cases to reach are results that sit exactly on a clamp boundary: a lane sum of exactly 2^w, a difference of exactly −1, and a sum of exactly 2^w−1 that must not clamp. Random operands reach these only rarely, so the bench drives them directly in every mode. The same holds for mixed words where one lane clamps while its neighbour must stay exact. The exchange operations get operands whose halfwords differ, so that a missing swap or a swapped add and subtract shows up in the result.

// File: rtl/psat_pkg.sv
package psat_pkg;
    typedef enum logic [2:0] {
        OP_ADD_H  = 3'b000,
        OP_ADD_B  = 3'b001,
        OP_SUB_H  = 3'b010,
        OP_SUB_B  = 3'b011,
        OP_XSUB   = 3'b100,
        OP_XADD   = 3'b101,
        OP_RSV_6  = 3'b110,
        OP_RSV_7  = 3'b111
    } psat_op_e;
endpackage

// File: rtl/psat_lane.sv
module psat_lane #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         sub_i,
    output logic [W-1:0] r_o,
    output logic         sat_o
);
    logic [W:0] wide;

    always_comb begin
        if (sub_i) wide = {1'b0, x_i} - {1'b0, y_i};
        else       wide = {1'b0, x_i} + {1'b0, y_i};
        sat_o = wide[W];
        if (!wide[W])   r_o = wide[W-1:0];
        else if (sub_i) r_o = '0;
        else            r_o = '1;
    end

    // R1
    add_not_below_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sub_i |-> (r_o >= x_i));
    // R3
    sub_not_above_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sub_i |-> (r_o <= x_i));
    // R7
    exact_when_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sat_o && !sub_i) |-> (r_o - x_i == y_i));
endmodule

// File: rtl/psat_route.sv
module psat_route
    import psat_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_half_o,
    output logic [1:0]        sub_half_o,
    output logic              sub_byte_o,
    output logic              is_half_o,
    output logic              is_valid_o
);
    psat_op_e op;
    assign op = psat_op_e'(op_i);

    logic [DATA_W-1:0] b_swapped;
    assign b_swapped = {b_i[HALF_W-1:0], b_i[DATA_W-1:HALF_W]};

    always_comb begin
        y_half_o   = b_i;
        sub_half_o = 2'b00;
        sub_byte_o = 1'b0;
        is_half_o  = 1'b1;
        is_valid_o = 1'b1;
        unique case (op)
            OP_ADD_H: ;
            OP_ADD_B: is_half_o = 1'b0;
            OP_SUB_H: sub_half_o = 2'b11;
            OP_SUB_B: begin
                is_half_o  = 1'b0;
                sub_byte_o = 1'b1;
            end
            OP_XSUB: begin
                y_half_o   = b_swapped;
                sub_half_o = 2'b01;
            end
            OP_XADD: begin
                y_half_o   = b_swapped;
                sub_half_o = 2'b10;
            end
            OP_RSV_6, OP_RSV_7: is_valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/psat_outreg.sv
module psat_outreg #(
    parameter int DATA_W  = 32,
    parameter int SAT_W   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] res_i,
    input  logic [SAT_W-1:0]  sat_i,
    output logic [DATA_W-1:0] res_o,
    output logic [SAT_W-1:0]  sat_o
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                res_o <= '0;
                sat_o <= '0;
            end else begin
                res_o <= res_i;
                sat_o <= sat_i;
            end
        end
    end else begin : g_comb
        assign res_o = rst_ni ? res_i : '0;
        assign sat_o = rst_ni ? sat_i : '0;
    end
endmodule

// File: rtl/psat_unit.sv
module psat_unit #(
    parameter int DATA_W  = 32,
    parameter int BYTE_W  = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int HALF_W = DATA_W / 2,
    localparam int N_BYTE = DATA_W / BYTE_W,
    localparam int B_PER_H = HALF_W / BYTE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic [N_BYTE-1:0] sat_o
);
    logic [DATA_W-1:0] y_half;
    logic [1:0]        sub_half;
    logic              sub_byte, is_half, is_valid;

    psat_route #(.DATA_W(DATA_W)) route_i (
        .op_i(op_i), .b_i(b_i), .y_half_o(y_half), .sub_half_o(sub_half),
        .sub_byte_o(sub_byte), .is_half_o(is_half), .is_valid_o(is_valid)
    );

    logic [DATA_W-1:0] h_res, b_res, res_c;
    logic [1:0]        h_sat;
    logic [N_BYTE-1:0] b_sat, sat_c;

    for (genvar g = 0; g < 2; g++) begin : g_half
        psat_lane #(.W(HALF_W)) lane_i (
            .clk_i(clk_i), .rst_ni(rst_ni),
            .x_i(a_i[g*HALF_W +: HALF_W]), .y_i(y_half[g*HALF_W +: HALF_W]),
            .sub_i(sub_half[g]), .r_o(h_res[g*HALF_W +: HALF_W]), .sat_o(h_sat[g])
        );
    end

    for (genvar k = 0; k < N_BYTE; k++) begin : g_byte
        psat_lane #(.W(BYTE_W)) lane_i (
            .clk_i(clk_i), .rst_ni(rst_ni),
            .x_i(a_i[k*BYTE_W +: BYTE_W]), .y_i(b_i[k*BYTE_W +: BYTE_W]),
            .sub_i(sub_byte), .r_o(b_res[k*BYTE_W +: BYTE_W]), .sat_o(b_sat[k])
        );
        assign sat_c[k] = !is_valid ? 1'b0 : (is_half ? h_sat[k / B_PER_H] : b_sat[k]);
    end

    assign res_c = !is_valid ? '0 : (is_half ? h_res : b_res);

    psat_outreg #(.DATA_W(DATA_W), .SAT_W(N_BYTE), .REG_OUT(REG_OUT)) out_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .res_i(res_c), .sat_i(sat_c),
        .res_o(res_o), .sat_o(sat_o)
    );

    // R8
    rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i[2:1] == 2'b11) |-> (res_c == '0 && sat_c == '0));
    // R9
    half_sat_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i != 3'b001 && op_i != 3'b011) |->
        (sat_c[0] == sat_c[B_PER_H-1] && sat_c[N_BYTE-1] == sat_c[B_PER_H]));
    // R5
    xsub_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'b100) |->
        (res_c[HALF_W-1:0] <= a_i[HALF_W-1:0] && res_c[DATA_W-1:HALF_W] >= a_i[DATA_W-1:HALF_W]));
    // R6
    xadd_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'b101) |->
        (res_c[HALF_W-1:0] >= a_i[HALF_W-1:0] && res_c[DATA_W-1:HALF_W] <= a_i[DATA_W-1:HALF_W]));
endmodule

// File: tb/psat_unit_tb_top.sv
module psat_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [31:0] a = '0, b = '0;
    logic [31:0] res;
    logic [3:0]  sat;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psat_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
        .res_o(res), .sat_o(sat)
    );

    function automatic logic [16:0] clamp(input int x, input int y, input bit sub, input int w);
        int s = sub ? x - y : x + y;
        int top = (1 << w) - 1;
        if (s < 0)   return {1'b1, 16'h0};
        if (s > top) return {1'b1, 16'(top)};
        return {1'b0, 16'(s)};
    endfunction

    task automatic model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                         output logic [31:0] r, output logic [3:0] s);
        logic [16:0] lo, hi;
        r = '0; s = '0;
        if (o == 3'b001 || o == 3'b011) begin
            for (int k = 0; k < 4; k++) begin
                lo = clamp(int'(x[k*8 +: 8]), int'(y[k*8 +: 8]), o == 3'b011, 8);
                r[k*8 +: 8] = lo[7:0];
                s[k] = lo[16];
            end
        end else if (o <= 3'b101) begin
            case (o)
                3'b000: begin lo = clamp(int'(x[15:0]), int'(y[15:0]), 0, 16);
                              hi = clamp(int'(x[31:16]), int'(y[31:16]), 0, 16); end
                3'b010: begin lo = clamp(int'(x[15:0]), int'(y[15:0]), 1, 16);
                              hi = clamp(int'(x[31:16]), int'(y[31:16]), 1, 16); end
                3'b100: begin lo = clamp(int'(x[15:0]), int'(y[31:16]), 1, 16);
                              hi = clamp(int'(x[31:16]), int'(y[15:0]), 0, 16); end
                default: begin lo = clamp(int'(x[15:0]), int'(y[31:16]), 0, 16);
                              hi = clamp(int'(x[31:16]), int'(y[15:0]), 1, 16); end
            endcase
            r = {hi[15:0], lo[15:0]};
            s = {hi[16], hi[16], lo[16], lo[16]};
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                         input string tag);
        logic [31:0] er; logic [3:0] es;
        @(negedge clk);
        op = o; a = x; b = y;
        @(posedge clk);
        @(negedge clk);
        model(o, x, y, er, es);
        n_chk++;
        if (res !== er || sat !== es) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h: got res=%h sat=%b expected res=%h sat=%b",
                     tag, o, x, y, res, sat, er, es);
        end
    endtask

    task automatic boundaries(input logic [2:0] o, input string tag);
        apply(o, 32'h0000_0000, 32'h0000_0000, tag);
        apply(o, 32'hFFFF_FFFF, 32'hFFFF_FFFF, tag);
        apply(o, 32'hFFFF_FFFF, 32'h0000_0000, tag);
        apply(o, 32'h0000_0000, 32'hFFFF_FFFF, tag);
        apply(o, 32'h8000_0001, 32'h8000_FFFF, tag);
        apply(o, 32'h8080_8001, 32'h8080_80FF, tag);
        apply(o, 32'h0000_0000, 32'h0001_0001, tag);
        apply(o, 32'h0000_0000, 32'h0101_0101, tag);
        apply(o, 32'hFFFE_0001, 32'h0001_FFFE, tag);
        apply(o, 32'hFE01_7F80, 32'h01FE_807F, tag);
        apply(o, 32'h1234_0005, 32'h0006_1235, tag);
    endtask

    task automatic t_reset();
        op = 3'b000; a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (res !== '0 || sat !== '0) begin
            n_fail++;
            $display("FAIL R10 reset: got res=%h sat=%b expected res=00000000 sat=0000", res, sat);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_add16();
        boundaries(3'b000, "R1");
        apply(3'b000, 32'hFFFF_0001, 32'h0001_0001, "R7 one halfword clamps");
    endtask
    task automatic t_add8();
        boundaries(3'b001, "R2");
        apply(3'b001, 32'h01FF_01FF, 32'h0101_0101, "R7 alternating byte clamps");
    endtask
    task automatic t_sub16();
        boundaries(3'b010, "R3");
        apply(3'b010, 32'h0000_0005, 32'h0001_0003, "R7 borrow isolation");
    endtask
    task automatic t_sub8();
        boundaries(3'b011, "R4");
        apply(3'b011, 32'h0005_0005, 32'h0100_0100, "R7 byte borrow isolation");
    endtask
    task automatic t_xsub();
        boundaries(3'b100, "R5");
        apply(3'b100, 32'h1000_0030, 32'h0020_0001, "R5 swap exact");
    endtask
    task automatic t_xadd();
        boundaries(3'b101, "R6");
        apply(3'b101, 32'h1000_0030, 32'h0020_0001, "R6 swap exact");
    endtask
    task automatic t_reserved();
        apply(3'b110, 32'hFFFF_FFFF, 32'h0001_0001, "R8 code 110");
        apply(3'b111, 32'h1234_5678, 32'hFFFF_FFFF, "R8 code 111");
    endtask
    task automatic t_random();
        for (int i = 0; i < 300; i++)
            apply(3'($urandom_range(0, 7)), $urandom, $urandom, "R9 random");
    endtask

    initial begin
        t_reset();
        t_add16();
        t_add8();
        t_sub16();
        t_sub8();
        t_xsub();
        t_xadd();
        t_reserved();
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule